// File: doc/BRIEF.md
# Control-Transfer Slot Guard

This block watches the in-order stream of decoded instructions and decides whether each instruction may legally sit where it sits. A classic branch or jump opens a delay slot: the next instruction is executed normally. A compact conditional branch opens a forbidden slot. An unconditional compact branch or jump opens no slot at all. When an instruction in either kind of slot is itself a control-transfer instruction (CTI), the block raises a one-cycle reserved-instruction exception.

The block sits beside the decode stage and takes one 32-bit instruction word with a valid strobe. It reports the slot that the next valid instruction will occupy, and it raises the exception pulse combinationally with the offending instruction's strobe. Executing branches is outside its function. Cycles without a valid strobe leave its state untouched.

Top module: `cti_slot_guard`

## Requirements
- R1: While reset is asserted, and after it is released until the first valid instruction, both slot flags and the exception output are 0.
- R2: A valid instruction opens a delay slot (`in_delay_slot`=1 from the next cycle) when its opcode field [31:26] is 2, 3, 4 or 5; or is 1 with rt [20:16] equal to 0 or 1; or is 6 or 7 with rt=0; or is 0 with function field [5:0] equal to 9.
- R3: A valid instruction opens a forbidden slot (`in_forbid_slot`=1 from the next cycle) when its opcode is 8, 22, 23 or 24; or is 6 or 7 with rt≠0; or is 54 or 62 with rs [25:21] ≠ 0.
- R4: Opcodes 50 and 58, and opcodes 54 and 62 with rs=0, are CTIs that open no slot.
- R5: Opcode 16 with bit 25 set and function 24, 31 or 32, and the word 0x00000140, are CTIs that open no slot. Every other word is not a CTI and opens no slot.
- R6: `rsvd_exc` is 1 in exactly the cycles where `instr_valid` is 1, a slot flag is 1, and the word is a CTI under R2 to R5.
- R7: A non-CTI instruction in a delay or forbidden slot raises no exception, and it closes the slot.
- R8: Cycles with `instr_valid`=0 leave both slot flags unchanged.
- R9: An instruction that raises `rsvd_exc` opens no slot of its own: both flags are 0 in the next cycle.
- R10: At most one slot flag is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_valid | input | 1 | Strobe qualifying `instr` |
| instr | input | 32 | Decoded instruction word |
| in_delay_slot | output | 1 | The next valid instruction occupies a delay slot |
| in_forbid_slot | output | 1 | The next valid instruction occupies a forbidden slot |
| rsvd_exc | output | 1 | Reserved-instruction exception, one cycle, with the offending strobe |

## Verification
Every cycle, the assertions check that the flags are mutually exclusive, that idle cycles hold them, that the exception only appears with a strobe inside an open slot, and that a faulting instruction leaves no slot behind. Whether each opcode and register-field combination lands in the right class, and so opens the right slot or triggers the fault, can only be shown by the bench's sweep. That sweep pairs every opcode under several rs, rt and function values with a set of probe instructions placed in the resulting slot.

// File: rtl/cti_slot_pkg.sv
package cti_slot_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned OP_W    = 6;
  localparam int unsigned REG_W   = 5;
  localparam int unsigned FN_W    = 6;
  localparam int unsigned OP_LSB  = WORD_W - OP_W;
  localparam int unsigned RS_LSB  = OP_LSB - REG_W;
  localparam int unsigned RT_LSB  = RS_LSB - REG_W;
  localparam int unsigned CO_BIT  = OP_LSB - 1;

  typedef enum logic [1:0] {
    SLOT_NONE   = 2'd0,
    SLOT_DELAY  = 2'd1,
    SLOT_FORBID = 2'd2
  } slot_kind_e;

  typedef struct packed {
    logic       cti;
    slot_kind_e kind;
  } cti_class_t;

  localparam logic [OP_W-1:0] OPC_SPECIAL = 6'd0;
  localparam logic [OP_W-1:0] OPC_REGIMM  = 6'd1;
  localparam logic [OP_W-1:0] OPC_JMP     = 6'd2;
  localparam logic [OP_W-1:0] OPC_JMPL    = 6'd3;
  localparam logic [OP_W-1:0] OPC_BREQ    = 6'd4;
  localparam logic [OP_W-1:0] OPC_BRNE    = 6'd5;
  localparam logic [OP_W-1:0] OPC_BRLE    = 6'd6;
  localparam logic [OP_W-1:0] OPC_BRGT    = 6'd7;
  localparam logic [OP_W-1:0] OPC_CMPA    = 6'd8;
  localparam logic [OP_W-1:0] OPC_SYSCP   = 6'd16;
  localparam logic [OP_W-1:0] OPC_CMPGE   = 6'd22;
  localparam logic [OP_W-1:0] OPC_CMPLT   = 6'd23;
  localparam logic [OP_W-1:0] OPC_CMPB    = 6'd24;
  localparam logic [OP_W-1:0] OPC_UBR     = 6'd50;
  localparam logic [OP_W-1:0] OPC_ZCMP0   = 6'd54;
  localparam logic [OP_W-1:0] OPC_UBRL    = 6'd58;
  localparam logic [OP_W-1:0] OPC_ZCMP1   = 6'd62;

  localparam logic [FN_W-1:0] FN_JREG     = 6'd9;
  localparam logic [FN_W-1:0] FN_EXC_RET  = 6'd24;
  localparam logic [FN_W-1:0] FN_DBG_RET  = 6'd31;
  localparam logic [FN_W-1:0] FN_IDLE     = 6'd32;

  localparam logic [WORD_W-1:0] WORD_SPIN_HINT = 32'h0000_0140;

endpackage

// File: rtl/cti_classifier.sv
module cti_classifier
  import cti_slot_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output cti_class_t        cls
);

  logic [OP_W-1:0]  opc;
  logic [REG_W-1:0] rs_f;
  logic [REG_W-1:0] rt_f;
  logic [FN_W-1:0]  fn_f;
  logic             rt_zero;
  logic             rs_zero;
  logic             sys_ret;

  assign opc     = word[WORD_W-1:OP_LSB];
  assign rs_f    = word[OP_LSB-1:RS_LSB];
  assign rt_f    = word[RS_LSB-1:RT_LSB];
  assign fn_f    = word[FN_W-1:0];
  assign rt_zero = (rt_f == '0);
  assign rs_zero = (rs_f == '0);
  assign sys_ret = word[CO_BIT] &&
                   ((fn_f == FN_EXC_RET) || (fn_f == FN_DBG_RET) || (fn_f == FN_IDLE));

  always_comb begin
    cls.cti  = 1'b0;
    cls.kind = SLOT_NONE;
    case (opc)
      OPC_JMP, OPC_JMPL, OPC_BREQ, OPC_BRNE: begin
        cls.cti  = 1'b1;
        cls.kind = SLOT_DELAY;
      end
      OPC_REGIMM: begin
        if (rt_f[REG_W-1:1] == '0) begin
          cls.cti  = 1'b1;
          cls.kind = SLOT_DELAY;
        end
      end
      OPC_BRLE, OPC_BRGT: begin
        cls.cti  = 1'b1;
        cls.kind = rt_zero ? SLOT_DELAY : SLOT_FORBID;
      end
      OPC_SPECIAL: begin
        if (fn_f == FN_JREG) begin
          cls.cti  = 1'b1;
          cls.kind = SLOT_DELAY;
        end else if (word == WORD_SPIN_HINT) begin
          cls.cti  = 1'b1;
        end
      end
      OPC_CMPA, OPC_CMPB, OPC_CMPGE, OPC_CMPLT: begin
        cls.cti  = 1'b1;
        cls.kind = SLOT_FORBID;
      end
      OPC_ZCMP0, OPC_ZCMP1: begin
        cls.cti  = 1'b1;
        cls.kind = rs_zero ? SLOT_NONE : SLOT_FORBID;
      end
      OPC_UBR, OPC_UBRL: begin
        cls.cti  = 1'b1;
      end
      OPC_SYSCP: begin
        cls.cti  = sys_ret;
      end
      default: begin
        cls.cti  = 1'b0;
        cls.kind = SLOT_NONE;
      end
    endcase
  end

endmodule

// File: rtl/slot_fault_gen.sv
module slot_fault_gen
  import cti_slot_pkg::*;
(
  input  logic       strobe,
  input  logic       word_is_cti,
  input  slot_kind_e cur_slot,
  output logic       fault
);

  logic slot_open;

  assign slot_open = (cur_slot != SLOT_NONE);
  assign fault     = strobe && slot_open && word_is_cti;

endmodule

// File: rtl/slot_state_reg.sv
module slot_state_reg
  import cti_slot_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       fault,
  input  slot_kind_e opened,
  output slot_kind_e cur_slot
);

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int_n;
  slot_kind_e             slot_d;
  slot_kind_e             slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  always_comb begin
    slot_d = slot_q;
    if (step) begin
      slot_d = fault ? SLOT_NONE : opened;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      slot_q <= SLOT_NONE;
    end else if (step) begin
      slot_q <= slot_d;
    end
  end

  assign cur_slot = slot_q;

endmodule

// File: rtl/cti_slot_guard.sv
module cti_slot_guard
  import cti_slot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [WORD_W-1:0] instr,
  output logic              in_delay_slot,
  output logic              in_forbid_slot,
  output logic              rsvd_exc
);

  cti_class_t cls;
  slot_kind_e cur_slot;
  logic       fault;

  cti_classifier u_cls (
    .word (instr),
    .cls  (cls)
  );

  slot_fault_gen u_fault (
    .strobe      (instr_valid),
    .word_is_cti (cls.cti),
    .cur_slot    (cur_slot),
    .fault       (fault)
  );

  slot_state_reg #(.SYNC_STAGES(2)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (instr_valid),
    .fault    (fault),
    .opened   (cls.kind),
    .cur_slot (cur_slot)
  );

  assign in_delay_slot  = (cur_slot == SLOT_DELAY);
  assign in_forbid_slot = (cur_slot == SLOT_FORBID);
  assign rsvd_exc       = fault;

endmodule

// File: rtl/cti_slot_guard_sva.sv
module cti_slot_guard_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        instr_valid,
  input logic [31:0] instr,
  input logic        in_delay_slot,
  input logic        in_forbid_slot,
  input logic        rsvd_exc
);

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_delay_slot && in_forbid_slot)); // R10

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> ($stable(in_delay_slot) && $stable(in_forbid_slot))); // R8

  AST_EXC_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_exc |-> instr_valid); // R6

  AST_EXC_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_exc |-> (in_delay_slot || in_forbid_slot)); // R6

  AST_FAULT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_exc |=> (!in_delay_slot && !in_forbid_slot)); // R9

  AST_ZERO_WORD_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr == 32'h0) |-> !rsvd_exc); // R7

endmodule

bind cti_slot_guard cti_slot_guard_sva u_sva (
  .clk            (clk),
  .rst_n          (rst_n),
  .instr_valid    (instr_valid),
  .instr          (instr),
  .in_delay_slot  (in_delay_slot),
  .in_forbid_slot (in_forbid_slot),
  .rsvd_exc       (rsvd_exc)
);

// File: tb/tb_cti_slot_guard.sv
`timescale 1ns/1ps
module tb_cti_slot_guard;

  logic        clk;
  logic        rst_n;
  logic        instr_valid;
  logic [31:0] instr;
  logic        in_delay_slot;
  logic        in_forbid_slot;
  logic        rsvd_exc;

  int checks;
  int errors;
  bit done;

  cti_slot_guard dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .instr_valid    (instr_valid),
    .instr          (instr),
    .in_delay_slot  (in_delay_slot),
    .in_forbid_slot (in_forbid_slot),
    .rsvd_exc       (rsvd_exc)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Expected class from the requirements: {cti, delay, forbid}
  function automatic logic [2:0] expect_cls(input logic [31:0] w);
    int op, rs, rt, fn;
    op = int'(w[31:26]); rs = int'(w[25:21]); rt = int'(w[20:16]); fn = int'(w[5:0]);
    if (op == 2 || op == 3 || op == 4 || op == 5) return 3'b110;          // R2
    if (op == 1) return (rt <= 1) ? 3'b110 : 3'b000;                       // R2
    if (op == 6 || op == 7) return (rt == 0) ? 3'b110 : 3'b101;            // R2 R3
    if (op == 0 && fn == 9) return 3'b110;                                 // R2
    if (op == 8 || op == 22 || op == 23 || op == 24) return 3'b101;        // R3
    if (op == 54 || op == 62) return (rs == 0) ? 3'b100 : 3'b101;          // R3 R4
    if (op == 50 || op == 58) return 3'b100;                               // R4
    if (op == 16 && w[25] && (fn == 24 || fn == 31 || fn == 32)) return 3'b100; // R5
    if (w == 32'h0000_0140) return 3'b100;                                 // R5
    return 3'b000;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (instr %08h)", req, act, exp, instr);
    end
  endtask

  task automatic chk_flags(input string req, input logic d, input logic f);
    chk(in_delay_slot == d && in_forbid_slot == f, req,
        int'({in_delay_slot, in_forbid_slot}), int'({d, f}));
  endtask

  // Drive at negedge, sample exception before posedge, flags after it
  task automatic issue(input logic [31:0] w, input logic exp_exc, input string req);
    instr_valid = 1'b1;
    instr = w;
    #1;
    chk(rsvd_exc == exp_exc, req, int'(rsvd_exc), int'(exp_exc));
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  initial begin
    logic [31:0] probes [8];
    int rt_set [3];
    int rs_set [2];
    int fn_set [3];
    checks = 0; errors = 0; done = 1'b0;
    probes = '{32'h0000_0000, 32'hC800_0010, 32'hD800_0004, 32'h1022_0003,
               32'h4200_0018, 32'h4200_0020, 32'h0000_0140, 32'h2422_0005};
    rt_set = '{0, 1, 7};
    rs_set = '{0, 17};
    fn_set = '{0, 9, 24};
    rst_n = 1'b0; instr_valid = 1'b0; instr = 32'h1000_0001;
    repeat (3) @(negedge clk);
    chk_flags("R1 in reset", 1'b0, 1'b0);
    chk(rsvd_exc == 1'b0, "R1 exc in reset", int'(rsvd_exc), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_flags("R1 after release", 1'b0, 1'b0);
    // First word after reset is a CTI: never treated as slot content
    issue(32'hC800_0001, 1'b0, "R1 first word");

    for (int op = 0; op < 64; op++) begin
      for (int a = 0; a < 3; a++) begin
        for (int b = 0; b < 2; b++) begin
          for (int c = 0; c < 3; c++) begin
            for (int p = 0; p < 8; p++) begin
              logic [31:0] wa;
              logic [2:0]  ca, cb;
              logic        slot_open, fexp;
              wa = {op[5:0], rs_set[b][4:0], rt_set[a][4:0], 10'd0, fn_set[c][5:0]};
              ca = expect_cls(wa);
              cb = expect_cls(probes[p]);
              issue(32'h0000_0000, 1'b0, "R7 clearing word");
              chk_flags("R7 slot closed", 1'b0, 1'b0);
              issue(wa, 1'b0, "R6 no slot open");
              chk_flags(ca[1] ? "R2 delay opened" : (ca[0] ? "R3 forbid opened" : "R4 R5 no slot"),
                        ca[1], ca[0]);
              @(negedge clk);
              chk_flags("R8 idle hold", ca[1], ca[0]);
              slot_open = ca[1] | ca[0];
              fexp = slot_open & cb[2];
              issue(probes[p], fexp, slot_open ? "R6 slot content" : "R7 outside slot");
              if (fexp) chk_flags("R9 fault closes", 1'b0, 1'b0);
              else      chk_flags("R10 next slot", cb[1], cb[0]);
            end
          end
        end
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule